// File: doc/BRIEF.md
# Interruptible Block Copy Engine

This engine moves a run of bytes from a source byte address to a destination byte address through a 32-bit memory port. Software programs three architectural values (source address, destination address and remaining length) and pulses a start strobe. The copy is made of steps. While the destination is not word-aligned, each step moves one byte. Once the destination is aligned and at least a full word remains, each step moves a whole word. Any remainder shorter than a word is moved one byte per step. A word step whose source is not word-aligned builds the destination word from two adjacent source words. The most recently fetched source word is kept in a private staging register, so that following steps do not fetch it again.

An interrupt request never splits a step. The engine finishes the step in progress, commits the updated source, destination and length, drops busy without a done pulse, and invalidates its staging register. To resume, software starts the engine again with the three values it reads back. Because each step's kind depends only on those values, the resumed copy issues exactly the writes that the uninterrupted copy would still have issued.

The memory port has three valid/ready channels: read request, read response and write. A request holds its payload until ready is seen. Only one read or one write is outstanding at any time, and the engine never presents a read request and a write in the same cycle. Back-pressure on any channel only stretches the step.

Top module: `blkcpy_engine`

## Requirements
- R1: After reset, busy, done, read request valid and write valid are low, and the source, destination and length outputs read zero.
- R2: A start with length zero raises done for exactly the cycle after start is accepted. Busy stays low and no read or write request is made.
- R3: While the destination's two low bits are nonzero, each step writes the single source byte at `src` into byte lane `dst[1:0]` (strobe bit `dst[1:0]`, lane k = data bits 8k+7:8k) of the word at `dst` with its low two bits cleared. Source and destination then advance by 1 and length drops by 1.
- R4: With an aligned destination and length of at least 4, a step writes strobe 4'b1111 to `dst`, with lane k carrying source byte `src+k`. Source and destination then advance by 4 and length drops by 4.
- R5: With an aligned destination and length below 4, the remaining bytes are written one per step, as in R3.
- R6: For every relative alignment of source and destination (both low-bit pairs 0 to 3), the destination range ends equal to the source range, and the bytes adjacent to it are unchanged.
- R7: Read request valid and write valid are never high together. A stalled request keeps valid and its payload until accepted.
- R8: An interrupt takes effect at the next step boundary. Exactly one more write completes, or none if the interrupt coincides with a write handshake. Busy then falls without done, and source and destination have each advanced by exactly the amount length has dropped.
- R9: Staging state is discarded at every start. The first memory transaction after any start, including a restart, is a read. A restart from the read-back values reproduces the remaining write sequence.
- R10: On the last write handshake, done pulses for one cycle as busy falls, and the length output reads zero.
- R11: A start pulse while busy is ignored.
- R12: An uninterrupted copy reads each source word it touches exactly once: read count = (last source word index) − (first source word index) + 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start strobe, taken only while idle |
| src_i | input | ADDR_W | Source byte address loaded at start |
| dst_i | input | ADDR_W | Destination byte address loaded at start |
| len_i | input | LEN_W | Byte count loaded at start |
| intr_i | input | 1 | Interrupt request, honoured at the next step boundary |
| src_o | output | ADDR_W | Current source address |
| dst_o | output | ADDR_W | Current destination address |
| len_o | output | LEN_W | Bytes still to copy |
| busy_o | output | 1 | Copy in progress |
| done_o | output | 1 | One-cycle pulse on normal completion |
| rd_req_valid_o | output | 1 | Read request valid |
| rd_req_ready_i | input | 1 | Read request accepted |
| rd_req_addr_o | output | ADDR_W | Word-aligned read address |
| rd_rsp_valid_i | input | 1 | Read data valid |
| rd_rsp_ready_o | output | 1 | Engine waiting for read data |
| rd_rsp_data_i | input | DATA_W | Read data |
| wr_valid_o | output | 1 | Write valid |
| wr_ready_i | input | 1 | Write accepted |
| wr_addr_o | output | ADDR_W | Word-aligned write address |
| wr_data_o | output | DATA_W | Write data, byte lanes |
| wr_strb_o | output | DATA_W/8 | Per-lane write enables |

## Verification
The hardest situation to reach is an interrupt that lands in the middle of the misaligned word phase. At that moment the staging register holds the upper half of the next merge, and a restart that wrongly reused it would write stale or skipped bytes. The bench sweeps all sixteen source/destination low-bit pairs and drives all three channels with random ready and response delays. It then injects one to four interrupts at random cycles and restarts from the read-back values each time. Every write is compared against a sequence precomputed from the step rules, and the first transaction after each restart is required to be a read.

// File: rtl/blkcpy_pkg.sv
`timescale 1ns/1ps
package blkcpy_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_PLAN  = 3'd1,
    ST_RDREQ = 3'd2,
    ST_RDRSP = 3'd3,
    ST_WRITE = 3'd4
  } cp_state_t;
endpackage

// File: rtl/blkcpy_step_plan.sv
`timescale 1ns/1ps
// Decides the kind of the next step from the architectural values only.
module blkcpy_step_plan #(
  parameter int LEN_W = 16,
  parameter int OFF_W = 2,
  parameter int LANES = 4
) (
  input  logic [OFF_W-1:0] src_off,
  input  logic [OFF_W-1:0] dst_off,
  input  logic [LEN_W-1:0] len,
  output logic             wide,
  output logic             pair
);
  localparam logic [LEN_W-1:0] LANES_L = LEN_W'(LANES);

  always_comb begin
    wide = (dst_off == '0) && (len >= LANES_L);
    pair = wide && (src_off != '0);
  end
endmodule

// File: rtl/blkcpy_stage_buf.sv
`timescale 1ns/1ps
// One tagged source word kept between steps; cleared on start and stop.
module blkcpy_stage_buf #(
  parameter int WA_W   = 30,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              load,
  input  logic [WA_W-1:0]   load_tag,
  input  logic [DATA_W-1:0] load_data,
  input  logic [WA_W-1:0]   probe_tag,
  output logic              hit,
  output logic [DATA_W-1:0] data
);
  logic              v_q;
  logic [WA_W-1:0]   tag_q;
  logic [DATA_W-1:0] data_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_q    <= 1'b0;
      tag_q  <= '0;
      data_q <= '0;
    end else if (flush) begin
      v_q <= 1'b0;
    end else if (load) begin
      v_q    <= 1'b1;
      tag_q  <= load_tag;
      data_q <= load_data;
    end
  end

  assign hit  = v_q && (tag_q == probe_tag);
  assign data = data_q;

  assert_flush_forgets_R9: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !hit);
endmodule

// File: rtl/blkcpy_lane_align.sv
`timescale 1ns/1ps
// Builds write data and strobes for a byte step or a word step.
module blkcpy_lane_align #(
  parameter int DATA_W = 32,
  parameter int LANES  = DATA_W / 8,
  parameter int OFF_W  = $clog2(LANES)
) (
  input  logic [DATA_W-1:0] lo_word,
  input  logic [DATA_W-1:0] hi_word,
  input  logic [OFF_W-1:0]  src_off,
  input  logic [OFF_W-1:0]  dst_off,
  input  logic              wide,
  output logic [DATA_W-1:0] wr_data,
  output logic [LANES-1:0]  wr_strb
);
  logic [2*DATA_W-1:0] joined;
  logic [2*DATA_W-1:0] shifted;
  logic [DATA_W-1:0]   lo_shift;
  logic [7:0]          one_byte;

  always_comb begin
    joined   = {hi_word, lo_word};
    shifted  = joined >> {src_off, 3'b000};
    lo_shift = lo_word >> {src_off, 3'b000};
    one_byte = lo_shift[7:0];
    if (wide) begin
      wr_data = shifted[DATA_W-1:0];
      wr_strb = '1;
    end else begin
      wr_data = {LANES{one_byte}};
      wr_strb = LANES'(1) << dst_off;
    end
  end
endmodule

// File: rtl/blkcpy_engine.sv
`timescale 1ns/1ps
module blkcpy_engine #(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 16,
  parameter int DATA_W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start_i,
  input  logic [ADDR_W-1:0]   src_i,
  input  logic [ADDR_W-1:0]   dst_i,
  input  logic [LEN_W-1:0]    len_i,
  input  logic                intr_i,
  output logic [ADDR_W-1:0]   src_o,
  output logic [ADDR_W-1:0]   dst_o,
  output logic [LEN_W-1:0]    len_o,
  output logic                busy_o,
  output logic                done_o,
  output logic                rd_req_valid_o,
  input  logic                rd_req_ready_i,
  output logic [ADDR_W-1:0]   rd_req_addr_o,
  input  logic                rd_rsp_valid_i,
  output logic                rd_rsp_ready_o,
  input  logic [DATA_W-1:0]   rd_rsp_data_i,
  output logic                wr_valid_o,
  input  logic                wr_ready_i,
  output logic [ADDR_W-1:0]   wr_addr_o,
  output logic [DATA_W-1:0]   wr_data_o,
  output logic [DATA_W/8-1:0] wr_strb_o
);
  import blkcpy_pkg::*;

  localparam int LANES = DATA_W / 8;
  localparam int OFF_W = $clog2(LANES);
  localparam int WA_W  = ADDR_W - OFF_W;
  localparam logic [LEN_W-1:0] LANES_L = LEN_W'(LANES);

  cp_state_t         st;
  logic [ADDR_W-1:0] src_q, dst_q;
  logic [LEN_W-1:0]  len_q;
  logic              done_q, irq_pend_q;
  logic              wide_q, pair_q, fetch_hi_q;
  logic [DATA_W-1:0] lo_q, hi_q;

  logic              plan_wide, plan_pair;
  logic              stage_hit;
  logic [DATA_W-1:0] stage_data;
  logic [WA_W-1:0]   src_word;
  logic [LEN_W-1:0]  step_len;
  logic [ADDR_W-1:0] step_addr;
  logic              wr_hs, last_step, start_acc, stop_evt, flush;

  assign src_word  = src_q[ADDR_W-1:OFF_W];
  assign step_len  = wide_q ? LANES_L : LEN_W'(1);
  assign step_addr = ADDR_W'(step_len);
  assign wr_hs     = (st == ST_WRITE) && wr_ready_i;
  assign last_step = (len_q == step_len);
  assign start_acc = (st == ST_IDLE) && start_i;
  assign stop_evt  = wr_hs && !last_step && (intr_i || irq_pend_q);
  assign flush     = start_acc || stop_evt;

  blkcpy_step_plan #(.LEN_W(LEN_W), .OFF_W(OFF_W), .LANES(LANES)) u_plan (
    .src_off (src_q[OFF_W-1:0]),
    .dst_off (dst_q[OFF_W-1:0]),
    .len     (len_q),
    .wide    (plan_wide),
    .pair    (plan_pair)
  );

  blkcpy_stage_buf #(.WA_W(WA_W), .DATA_W(DATA_W)) u_stage (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (flush),
    .load      (wr_hs),
    .load_tag  (pair_q ? src_word + WA_W'(1) : src_word),
    .load_data (pair_q ? hi_q : lo_q),
    .probe_tag (src_word),
    .hit       (stage_hit),
    .data      (stage_data)
  );

  blkcpy_lane_align #(.DATA_W(DATA_W), .LANES(LANES), .OFF_W(OFF_W)) u_align (
    .lo_word (lo_q),
    .hi_word (hi_q),
    .src_off (src_q[OFF_W-1:0]),
    .dst_off (dst_q[OFF_W-1:0]),
    .wide    (wide_q),
    .wr_data (wr_data_o),
    .wr_strb (wr_strb_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= ST_IDLE;
      src_q      <= '0;
      dst_q      <= '0;
      len_q      <= '0;
      done_q     <= 1'b0;
      irq_pend_q <= 1'b0;
      wide_q     <= 1'b0;
      pair_q     <= 1'b0;
      fetch_hi_q <= 1'b0;
      lo_q       <= '0;
      hi_q       <= '0;
    end else begin
      done_q <= 1'b0;
      if ((st != ST_IDLE) && intr_i) irq_pend_q <= 1'b1;
      unique case (st)
        ST_IDLE: begin
          if (start_i) begin
            src_q      <= src_i;
            dst_q      <= dst_i;
            len_q      <= len_i;
            irq_pend_q <= 1'b0;
            if (len_i == '0) done_q <= 1'b1;
            else             st     <= ST_PLAN;
          end
        end
        ST_PLAN: begin
          wide_q <= plan_wide;
          pair_q <= plan_pair;
          if (stage_hit) begin
            lo_q <= stage_data;
            if (plan_pair) begin
              fetch_hi_q <= 1'b1;
              st         <= ST_RDREQ;
            end else begin
              st <= ST_WRITE;
            end
          end else begin
            fetch_hi_q <= 1'b0;
            st         <= ST_RDREQ;
          end
        end
        ST_RDREQ: begin
          if (rd_req_ready_i) st <= ST_RDRSP;
        end
        ST_RDRSP: begin
          if (rd_rsp_valid_i) begin
            if (fetch_hi_q) begin
              hi_q <= rd_rsp_data_i;
              st   <= ST_WRITE;
            end else begin
              lo_q <= rd_rsp_data_i;
              if (pair_q) begin
                fetch_hi_q <= 1'b1;
                st         <= ST_RDREQ;
              end else begin
                st <= ST_WRITE;
              end
            end
          end
        end
        ST_WRITE: begin
          if (wr_ready_i) begin
            src_q <= src_q + step_addr;
            dst_q <= dst_q + step_addr;
            len_q <= len_q - step_len;
            if (last_step) begin
              done_q     <= 1'b1;
              irq_pend_q <= 1'b0;
              st         <= ST_IDLE;
            end else if (intr_i || irq_pend_q) begin
              irq_pend_q <= 1'b0;
              st         <= ST_IDLE;
            end else begin
              st <= ST_PLAN;
            end
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign src_o          = src_q;
  assign dst_o          = dst_q;
  assign len_o          = len_q;
  assign busy_o         = (st != ST_IDLE);
  assign done_o         = done_q;
  assign rd_req_valid_o = (st == ST_RDREQ);
  assign rd_req_addr_o  = {src_word + WA_W'(fetch_hi_q), {OFF_W{1'b0}}};
  assign rd_rsp_ready_o = (st == ST_RDRSP);
  assign wr_valid_o     = (st == ST_WRITE);
  assign wr_addr_o      = {dst_q[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};

  assert_one_side_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_req_valid_o && wr_valid_o));

  assert_rd_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req_valid_o && !rd_req_ready_i) |=> (rd_req_valid_o && $stable(rd_req_addr_o)));

  assert_wr_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid_o && !wr_ready_i) |=>
      (wr_valid_o && $stable(wr_addr_o) && $stable(wr_data_o) && $stable(wr_strb_o)));

  assert_progress_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid_o && wr_ready_i) |=>
      ((ADDR_W'($past(len_q) - len_q) == src_q - $past(src_q)) &&
       (dst_q - $past(dst_q) == src_q - $past(src_q))));

  assert_stop_boundary_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> $past(wr_valid_o && wr_ready_i));

  assert_done_len_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!busy_o && (len_o == '0)));
endmodule

// File: tb/blkcpy_engine_bench.sv
`timescale 1ns/1ps
module blkcpy_engine_bench;
  localparam int AW = 32;
  localparam int LW = 16;
  localparam int DW = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic          start_i = 1'b0;
  logic [AW-1:0] src_i = '0, dst_i = '0;
  logic [LW-1:0] len_i = '0;
  logic          intr_i = 1'b0;
  logic [AW-1:0] src_o, dst_o;
  logic [LW-1:0] len_o;
  logic          busy_o, done_o;
  logic          rd_req_valid_o, rd_req_ready_i = 1'b0;
  logic [AW-1:0] rd_req_addr_o;
  logic          rd_rsp_valid_i = 1'b0, rd_rsp_ready_o;
  logic [DW-1:0] rd_rsp_data_i = '0;
  logic          wr_valid_o, wr_ready_i = 1'b0;
  logic [AW-1:0] wr_addr_o;
  logic [DW-1:0] wr_data_o;
  logic [3:0]    wr_strb_o;

  blkcpy_engine #(.ADDR_W(AW), .LEN_W(LW), .DATA_W(DW)) u_blkcpy_engine (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .src_i(src_i), .dst_i(dst_i),
    .len_i(len_i), .intr_i(intr_i), .src_o(src_o), .dst_o(dst_o), .len_o(len_o),
    .busy_o(busy_o), .done_o(done_o), .rd_req_valid_o(rd_req_valid_o),
    .rd_req_ready_i(rd_req_ready_i), .rd_req_addr_o(rd_req_addr_o),
    .rd_rsp_valid_i(rd_rsp_valid_i), .rd_rsp_ready_o(rd_rsp_ready_o),
    .rd_rsp_data_i(rd_rsp_data_i), .wr_valid_o(wr_valid_o), .wr_ready_i(wr_ready_i),
    .wr_addr_o(wr_addr_o), .wr_data_o(wr_data_o), .wr_strb_o(wr_strb_o)
  );

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  logic [7:0] mem [0:1023];

  function automatic logic [31:0] mem_word(input logic [AW-1:0] a);
    int b;
    b = int'(a[9:0]) & ~3;
    return {mem[b+3], mem[b+2], mem[b+1], mem[b]};
  endfunction

  // expected write sequence built from the step rules
  logic [31:0] q_addr[$];
  logic [3:0]  q_strb[$];
  logic [31:0] q_data[$];
  int          q_kind[$];

  task automatic build_expect(input int s, input int d, input int n);
    q_addr.delete(); q_strb.delete(); q_data.delete(); q_kind.delete();
    while (n > 0) begin
      if ((d % 4) != 0 || n < 4) begin
        q_addr.push_back(32'(d & ~3));
        q_strb.push_back(4'(1 << (d % 4)));
        q_data.push_back(32'(mem[s]) << (8 * (d % 4)));
        q_kind.push_back(((d % 4) != 0) ? 3 : 5);
        s++; d++; n--;
      end else begin
        q_addr.push_back(32'(d));
        q_strb.push_back(4'hF);
        q_data.push_back({mem[s+3], mem[s+2], mem[s+1], mem[s]});
        q_kind.push_back(4);
        s += 4; d += 4; n -= 4;
      end
    end
  endtask

  // monitor and memory model state
  bit          rsp_pend = 0;
  int          rsp_cd = 0;
  logic [31:0] rsp_word = '0;
  bit          rd_stall = 0, wr_stall = 0;
  logic [31:0] rd_stall_addr = '0, wr_stall_addr = '0, wr_stall_data = '0;
  logic [3:0]  wr_stall_strb = '0;
  int          rd_count = 0, wr_count = 0;
  bit          exp_read_first = 0;
  bit          exp_done_next = 0;
  bit          zl_mode = 0;
  bit          done_seen = 0;
  bit          prev_busy = 0;
  bit          irq_armed = 0, irq_same = 0;
  int          wr_after = 0;
  logic [AW-1:0] base_src = '0, base_dst = '0;
  logic [LW-1:0] base_len = '0;

  always @(negedge clk) begin
    if (rst_n) begin
      bit rd_hs, wr_hs;
      // read response channel
      rd_rsp_valid_i = 1'b0;
      if (rsp_pend) begin
        if (rsp_cd == 0) begin
          rd_rsp_valid_i = 1'b1;
          rd_rsp_data_i  = rsp_word;
          if (rd_rsp_ready_o) rsp_pend = 0;
        end else begin
          rsp_cd--;
        end
      end
      // R7 channel rules
      chk(!(rd_req_valid_o && wr_valid_o), "R7", "read and write valid together",
          {rd_req_valid_o, wr_valid_o}, 0);
      if (rd_stall)
        chk(rd_req_valid_o && rd_req_addr_o == rd_stall_addr, "R7", "stalled read dropped or changed",
            rd_req_addr_o, rd_stall_addr);
      if (wr_stall)
        chk(wr_valid_o && wr_addr_o == wr_stall_addr && wr_data_o == wr_stall_data &&
            wr_strb_o == wr_stall_strb, "R7", "stalled write dropped or changed",
            {wr_addr_o, wr_data_o}, {wr_stall_addr, wr_stall_data});
      rd_req_ready_i = ($urandom_range(3) != 0);
      wr_ready_i     = ($urandom_range(3) != 0);
      rd_hs = rd_req_valid_o && rd_req_ready_i;
      wr_hs = wr_valid_o && wr_ready_i;
      rd_stall = rd_req_valid_o && !rd_req_ready_i;
      rd_stall_addr = rd_req_addr_o;
      wr_stall = wr_valid_o && !wr_ready_i;
      wr_stall_addr = wr_addr_o; wr_stall_data = wr_data_o; wr_stall_strb = wr_strb_o;

      // done expectation from previous final write (R10)
      if (!zl_mode && (exp_done_next || done_o))
        chk(done_o == exp_done_next && !busy_o && len_o == '0, "R10", "done pulse",
            {done_o, busy_o, len_o}, {exp_done_next, 1'b0, 16'h0});
      if (done_o) begin done_seen = 1; irq_armed = 0; end
      exp_done_next = 0;

      // interrupt stop (R8)
      if (prev_busy && !busy_o && !done_o) begin
        chk(irq_armed, "R8", "busy fell without interrupt or done", 0, 1);
        chk(wr_after == (irq_same ? 0 : 1), "R8", "writes after interrupt", wr_after, irq_same ? 0 : 1);
        chk((src_o - base_src) == AW'(base_len - len_o) && (dst_o - base_dst) == (src_o - base_src),
            "R8", "register progress", src_o - base_src, AW'(base_len - len_o));
        irq_armed = 0;
      end
      prev_busy = busy_o;

      if (rd_hs) begin
        rd_count++;
        if (exp_read_first) begin
          chk(1'b1, "R9", "first access is a read", 1, 1);
          exp_read_first = 0;
        end
        rsp_pend = 1;
        rsp_cd   = $urandom_range(2);
        rsp_word = mem_word(rd_req_addr_o);
      end
      if (wr_hs) begin
        wr_count++;
        if (exp_read_first) begin
          chk(1'b0, "R9", "write before any read after start", 1, 0);
          exp_read_first = 0;
        end
        if (q_addr.size() == 0) begin
          chk(1'b0, "R6", "unexpected write", wr_addr_o, 0);
        end else begin
          logic [31:0] m;
          string tag;
          for (int k = 0; k < 4; k++) m[8*k +: 8] = {8{q_strb[0][k]}};
          tag = (q_kind[0] == 3) ? "R3" : (q_kind[0] == 4) ? "R4" : "R5";
          chk(wr_addr_o == q_addr[0] && wr_strb_o == q_strb[0] && (wr_data_o & m) == q_data[0],
              tag, "write step", {wr_addr_o[15:0], wr_strb_o, wr_data_o & m},
              {q_addr[0][15:0], q_strb[0], q_data[0]});
          for (int k = 0; k < 4; k++)
            if (wr_strb_o[k]) mem[int'(wr_addr_o[9:0]) + k] = wr_data_o[8*k +: 8];
          void'(q_addr.pop_front()); void'(q_strb.pop_front());
          void'(q_data.pop_front()); void'(q_kind.pop_front());
          if (q_addr.size() == 0) exp_done_next = 1;
        end
      end
      if (intr_i) begin
        irq_armed = 1; irq_same = wr_hs; wr_after = 0;
      end else if (irq_armed && wr_hs) begin
        wr_after++;
      end
    end
  end

  task automatic do_start(input logic [AW-1:0] s, input logic [AW-1:0] d, input logic [LW-1:0] n);
    @(posedge clk); #1;
    src_i = s; dst_i = d; len_i = n; start_i = 1'b1;
    base_src = s; base_dst = d; base_len = n;
    if (n != 0) exp_read_first = 1;
    @(posedge clk); #1;
    start_i = 1'b0;
  endtask

  task automatic run_copy(input int s, input int d, input int n, input int n_irq, input bit poke);
    int irq_left;
    bit fin;
    for (int i = 0; i < 1024; i++) mem[i] = 8'($urandom);
    for (int i = 480; i < 640; i++) mem[i] = 8'hEE;
    build_expect(s, d, n);
    rd_count = 0; wr_count = 0; done_seen = 0; irq_armed = 0;
    irq_left = n_irq;
    do_start(AW'(s), AW'(d), LW'(n));
    if (poke) begin
      repeat (3) @(posedge clk);
      #1;
      chk(busy_o, "R11", "busy before second start", busy_o, 1);
      src_i = 32'h300; dst_i = 32'h10; len_i = 16'd9; start_i = 1'b1;
      @(posedge clk); #1 start_i = 1'b0;
    end
    fin = 0;
    while (!fin) begin
      if (irq_left > 0) begin
        repeat ($urandom_range(2, 20)) @(posedge clk);
        #1;
        if (busy_o) begin
          intr_i = 1'b1;
          @(posedge clk); #1 intr_i = 1'b0;
        end
        irq_left--;
      end
      while (busy_o) begin @(posedge clk); #1; end
      if (done_o || done_seen) fin = 1;
      else if (irq_left == 0 && !busy_o && q_addr.size() == 0) fin = 1;
      else if (irq_left == 0 || !busy_o) do_start(src_o, dst_o, len_o);
    end
    @(negedge clk); @(posedge clk); #1;
    chk(q_addr.size() == 0, "R9", "writes left after resumed copy", q_addr.size(), 0);
    begin
      int bad = 0;
      for (int i = 0; i < n; i++) if (mem[d+i] != mem[s+i]) bad++;
      if (mem[d-1] != 8'hEE) bad++;
      if (mem[d+n] != 8'hEE) bad++;
      chk(bad == 0, "R6", "destination contents", bad, 0);
    end
    if (n_irq == 0 && n > 0)
      chk(rd_count == ((s + n - 1) / 4 - s / 4 + 1), "R12", "read count",
          rd_count, (s + n - 1) / 4 - s / 4 + 1);
    if (poke)
      chk(len_o == 0 && dst_o == AW'(d + n), "R11", "second start ignored", dst_o, d + n);
  endtask

  initial begin
    int lens[7] = '{1, 2, 3, 4, 7, 13, 30};
    repeat (3) @(posedge clk);
    #1;
    chk(!busy_o && !done_o && !rd_req_valid_o && !wr_valid_o, "R1", "control outputs at reset",
        {busy_o, done_o, rd_req_valid_o, wr_valid_o}, 0);
    chk(src_o == 0 && dst_o == 0 && len_o == 0, "R1", "register outputs at reset",
        {src_o, len_o}, 0);
    rst_n = 1'b1;
    repeat (2) @(posedge clk);
    #1;
    // R2: zero length
    zl_mode = 1; rd_count = 0; wr_count = 0;
    do_start(32'h40, 32'h200, 16'd0);
    chk(done_o && !busy_o, "R2", "zero length done", {done_o, busy_o}, 2'b10);
    @(posedge clk); #1;
    chk(!done_o && !busy_o, "R2", "zero length done width", {done_o, busy_o}, 0);
    repeat (3) @(posedge clk);
    #1;
    chk(rd_count == 0 && wr_count == 0, "R2", "zero length memory traffic", rd_count + wr_count, 0);
    zl_mode = 0;
    // R3..R6, R10, R12: all alignments, no interrupts
    for (int so = 0; so < 4; so++)
      for (int dof = 0; dof < 4; dof++)
        foreach (lens[li]) run_copy(64 + so, 512 + dof, lens[li], 0, 1'b0);
    // R11
    run_copy(65, 514, 40, 0, 1'b1);
    // R8, R9: interrupted and resumed
    for (int t = 0; t < 40; t++)
      run_copy(64 + $urandom_range(3), 512 + $urandom_range(3), $urandom_range(20, 60),
               $urandom_range(1, 4), 1'b0);
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      chk(1'b0, "R10", "watchdog timeout", 150000, 0);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule